// File: doc/BRIEF.md
# Register-Mapped I2C Master Sequencer

This block is the software-facing front end of an I2C master. A host reaches it through single-byte register accesses: configuration registers, a data register, a control register and a status register. The status register carries a five-bit progress code. Accessing the data register starts bus phases as a side effect. Writing it after a start condition sends the target address. Writing it during a write transfer sends a payload byte. Reading it during a read transfer fetches the next received byte.

The bit-level wire timing is not part of this block. It drives an abstract byte-level port with four request kinds: start-with-address, send, receive and stop. Each request is a one-cycle strobe, and the bus side answers with a done pulse carrying an ack bit and, for a receive, a byte. While a request is outstanding, the host port holds off further accesses with a ready signal. An interrupt flag in the control register records each completed phase. A build parameter selects whether software clears that flag by writing 0 or by writing 1.

Top module: `i2cm_regfront`

## Requirements
- R1: After reset the status register reads 0xF8 (idle, code 31), line control reads 0x3A, and control, clock control, soft reset, slave address and data read 0x00. `irq_o` is low and `host_ready_o` is high.
- R2: The register offsets are:
  - 0x00: slave address, written in full.
  - 0x04: extended address, written in full.
  - 0x08: data.
  - 0x0C: control, write mask 0xFC.
  - 0x10: status, read-only, code in bits [7:3].
  - 0x14: clock control, mask 0x7F.
  - 0x18: soft reset, mask 0x01.
  - 0x1C: enhanced feature, mask 0x03.
  - 0x20: line control, mask 0x3F.

  Any other offset reads 0x00, and writes to it change nothing.
- R3: Control bits are interrupt enable [7], bus enable [6], start [5], stop [4], interrupt flag [3] and auto-ack [2]. A control write with start set moves the code to 1 from idle and to 2 from any other code, then clears start. A control write with stop set issues a stop request, sets the code to idle and clears stop.
- R4: A data write in code 1 or 2 issues a start request, using byte bits [7:1] as the address and bit 0 as the direction (1 means read). An ack gives code 8 for a read or code 3 for a write, and raises the flag. A nack gives code 4 and leaves the flag alone.
- R5: A data write in code 3 or 5 issues a send request with the byte. An ack gives code 5 and raises the flag. A nack gives code 6 and is followed by a stop request.
- R6: A data read in code 8, 10 or 11 issues a receive request and returns the received byte. The code then becomes 10 when auto-ack is set and 11 when it is clear, and the flag is raised. A status read in code 8 returns 0x40 and then moves the code to 10 or 11 by the same rule.
- R7: Raising the flag sets control bit 3 only if soft reset is clear, bus enable is set and the code is not idle. A start written through the control register also raises the flag. `irq_o` is high exactly when the flag and interrupt enable are both set and soft reset is clear.
- R8: With `CLR_ON_ONE`=0, writing 0 to flag bit 3 clears it and writing 1 keeps it. With `CLR_ON_ONE`=1 the roles swap.
- R9: A control write that clears auto-ack turns code 10 into 11. A control write that sets auto-ack turns code 11 into 10.
- R10: Data writes are ignored while soft reset is set or bus enable is clear: the data register is unchanged and no bus request is issued. Control writes are ignored while soft reset is set.
- R11: Writing 0 to soft reset while it holds 1 returns every register to its R1 value. If the code was not idle, it also issues a stop request.
- R12: A bus request is a single-cycle `bus_req_o` pulse. From the cycle after it is issued until the cycle after `bus_done_i`, `host_ready_o` is low. A read response is a one-cycle `rsp_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req_i | input | 1 | Register access strobe, taken when ready is high |
| host_wr_i | input | 1 | 1 = write, 0 = read |
| host_off_i | input | ADDR_W | Byte offset of the register |
| host_wdata_i | input | 8 | Write byte |
| host_ready_o | output | 1 | Block can take an access |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_data_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt output |
| bus_req_o | output | 1 | Bus request strobe |
| bus_op_o | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| bus_addr_o | output | 7 | Target address for start |
| bus_rnw_o | output | 1 | Direction for start, 1 = read |
| bus_wdata_o | output | 8 | Byte for send |
| bus_done_i | input | 1 | Request completed pulse |
| bus_ack_i | input | 1 | Target acknowledged |
| bus_rdata_i | input | 8 | Received byte |

## Verification
The bench targets the start/repeated-start split. A design that always reports code 1 would mis-code a restart issued after a failed send. It checks that an address nack leaves the flag clear, and that a send nack is followed by exactly one stop request; a design that raised on every completion, or dropped the chained stop, fails those checks. The status-read advance out of code 8 and the auto-ack swap between codes 10 and 11 are checked read by read. An off-by-one in the code update would return the wrong status on the second read. Finally, the bench checks that data writes are inert when the bus is disabled or soft reset is held, and that releasing soft reset mid-transfer both restores every register and issues one stop.

// File: rtl/i2cm_pkg.sv
// Package: shared constants and types of the I2C master register front end.
// Assumes byte-wide registers and a 5-bit status code placed in bits [7:3].
package i2cm_pkg;

    // Status codes (value held in status bits [7:3])
    localparam logic [4:0] ST_START   = 5'd1;
    localparam logic [4:0] ST_RSTART  = 5'd2;
    localparam logic [4:0] ST_AW_ACK  = 5'd3;
    localparam logic [4:0] ST_AW_NACK = 5'd4;
    localparam logic [4:0] ST_TX_ACK  = 5'd5;
    localparam logic [4:0] ST_TX_NACK = 5'd6;
    localparam logic [4:0] ST_AR_ACK  = 5'd8;
    localparam logic [4:0] ST_RX_ACK  = 5'd10;
    localparam logic [4:0] ST_RX_NACK = 5'd11;
    localparam logic [4:0] ST_IDLE    = 5'd31;

    // Register offsets
    localparam logic [7:0] OFF_SADDR = 8'h00;
    localparam logic [7:0] OFF_XADDR = 8'h04;
    localparam logic [7:0] OFF_DATA  = 8'h08;
    localparam logic [7:0] OFF_CTRL  = 8'h0C;
    localparam logic [7:0] OFF_STAT  = 8'h10;
    localparam logic [7:0] OFF_CLK   = 8'h14;
    localparam logic [7:0] OFF_SRST  = 8'h18;
    localparam logic [7:0] OFF_FEAT  = 8'h1C;
    localparam logic [7:0] OFF_LINE  = 8'h20;

    // Write masks and reset values
    localparam logic [7:0] MSK_CTRL = 8'hFC;
    localparam logic [7:0] MSK_CLK  = 8'h7F;
    localparam logic [7:0] MSK_FEAT = 8'h03;
    localparam logic [7:0] MSK_LINE = 8'h3F;
    localparam logic [7:0] RST_LINE = 8'h3A;

    // Control bit positions
    localparam int CB_IE  = 7;
    localparam int CB_EN  = 6;
    localparam int CB_STA = 5;
    localparam int CB_STP = 4;
    localparam int CB_FLG = 3;
    localparam int CB_AAK = 2;

    typedef enum logic [1:0] {
        BOP_START = 2'd0,
        BOP_SEND  = 2'd1,
        BOP_RECV  = 2'd2,
        BOP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        PW_NONE,
        PW_ADDR,
        PW_SEND,
        PW_RECV,
        PW_STOP
    } pend_e;

endpackage

// File: rtl/i2cm_bus_if.sv
// Module: issues one byte-level bus request at a time and tracks it.
// Assumes the bus side answers every request with exactly one done pulse;
// a done pulse seen while nothing is outstanding is ignored.
module i2cm_bus_if
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_i,
    input  bus_op_e    op_i,
    input  logic [6:0] addr_i,
    input  logic       rnw_i,
    input  logic [7:0] wbyte_i,
    input  logic       bus_done_i,
    output logic       bus_req_o,
    output bus_op_e    bus_op_o,
    output logic [6:0] bus_addr_o,
    output logic       bus_rnw_o,
    output logic [7:0] bus_wdata_o,
    output logic       busy_o,
    output logic       done_o
);

    logic busy_q;

    // Launch the request strobe and hold its fields until the next request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req_o   <= 1'b0;
            bus_op_o    <= BOP_STOP;
            bus_addr_o  <= '0;
            bus_rnw_o   <= 1'b0;
            bus_wdata_o <= '0;
        end else begin
            bus_req_o <= issue_i;
            if (issue_i) begin
                bus_op_o    <= op_i;
                bus_addr_o  <= addr_i;
                bus_rnw_o   <= rnw_i;
                bus_wdata_o <= wbyte_i;
            end
        end
    end

    // Outstanding flag: set on issue, cleared on completion unless re-issued
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (issue_i)
            busy_q <= 1'b1;
        else if (bus_done_i)
            busy_q <= 1'b0;
    end

    assign busy_o = busy_q;
    assign done_o = bus_done_i & busy_q;

endmodule

// File: rtl/i2cm_rdmux.sv
// Module: read-data selector for the register front end.
// Assumes the status code is presented unshifted; unknown offsets return 0.
module i2cm_rdmux
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] off_i,
    input  logic [7:0]        saddr_i,
    input  logic [7:0]        xaddr_i,
    input  logic [7:0]        data_i,
    input  logic [7:0]        ctrl_i,
    input  logic [4:0]        code_i,
    input  logic [7:0]        clk_i,
    input  logic              srst_i,
    input  logic [7:0]        feat_i,
    input  logic [7:0]        line_i,
    output logic [7:0]        value_o
);

    logic [7:0] off8;
    assign off8 = 8'(off_i);

    // Select the register image addressed by the offset
    always_comb begin
        case (off8)
            OFF_SADDR: value_o = saddr_i;
            OFF_XADDR: value_o = xaddr_i;
            OFF_DATA:  value_o = data_i;
            OFF_CTRL:  value_o = ctrl_i;
            OFF_STAT:  value_o = {code_i, 3'b000};
            OFF_CLK:   value_o = clk_i;
            OFF_SRST:  value_o = {7'd0, srst_i};
            OFF_FEAT:  value_o = feat_i;
            OFF_LINE:  value_o = line_i;
            default:   value_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/i2cm_ctrl.sv
// Module: register file and status-code sequencer of the I2C master.
// Assumes accesses arrive only while no bus request is outstanding, so an
// accepted access and a bus completion never fall in the same cycle.
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter bit CLR_ON_ONE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              acc_wr_i,
    input  logic [ADDR_W-1:0] acc_off_i,
    input  logic [7:0]        acc_wbyte_i,
    input  logic [7:0]        rd_value_i,
    input  logic              bdone_i,
    input  logic              back_i,
    input  logic [7:0]        brdata_i,
    output logic              issue_o,
    output bus_op_e           iop_o,
    output logic [6:0]        iaddr_o,
    output logic              irnw_o,
    output logic [7:0]        iwbyte_o,
    output logic [7:0]        saddr_o,
    output logic [7:0]        xaddr_o,
    output logic [7:0]        data_o,
    output logic [7:0]        ctrl_o,
    output logic [4:0]        code_o,
    output logic [7:0]        clk_o,
    output logic              srst_o,
    output logic [7:0]        feat_o,
    output logic [7:0]        line_o,
    output logic              irq_o,
    output logic              rsp_valid_o,
    output logic [7:0]        rsp_data_o
);

    logic [7:0] saddr_q, xaddr_q, data_q, ctrl_q, clk_q, feat_q, line_q;
    logic [4:0] code_q;
    logic       srst_q;
    pend_e      pend_q;

    logic [7:0] saddr_d, xaddr_d, data_d, ctrl_d, clk_d, feat_d, line_d;
    logic [4:0] code_d;
    logic       srst_d;
    pend_e      pend_d;
    logic       rsp_v_d;
    logic [7:0] rsp_b_d;
    logic [7:0] off8;

    assign off8 = 8'(acc_off_i);

    // Flag raise rule: only when out of soft reset, enabled and not idle
    function automatic logic [7:0] raise_flag(input logic srst, input logic [7:0] c,
                                              input logic [4:0] code);
        logic [7:0] r;
        r = c;
        if (!srst && c[CB_EN] && (code != ST_IDLE))
            r[CB_FLG] = 1'b1;
        return r;
    endfunction

    // Receive status chosen by the auto-ack setting
    function automatic logic [4:0] rx_code(input logic aak);
        return aak ? ST_RX_ACK : ST_RX_NACK;
    endfunction

    // Next-state logic: register writes, read side effects, bus completions
    always_comb begin
        logic [7:0] c_v;
        logic [4:0] k_v;
        logic       rs_v;
        saddr_d  = saddr_q;
        xaddr_d  = xaddr_q;
        data_d   = data_q;
        ctrl_d   = ctrl_q;
        code_d   = code_q;
        clk_d    = clk_q;
        srst_d   = srst_q;
        feat_d   = feat_q;
        line_d   = line_q;
        pend_d   = pend_q;
        rsp_v_d  = 1'b0;
        rsp_b_d  = rsp_data_o;
        issue_o  = 1'b0;
        iop_o    = BOP_STOP;
        iaddr_o  = acc_wbyte_i[7:1];
        irnw_o   = acc_wbyte_i[0];
        iwbyte_o = acc_wbyte_i;
        c_v      = ctrl_q;
        k_v      = code_q;
        rs_v     = 1'b0;

        if (bdone_i) begin
            pend_d = PW_NONE;
            case (pend_q)
                PW_ADDR: begin
                    if (back_i) begin
                        code_d = data_q[0] ? ST_AR_ACK : ST_AW_ACK;
                        ctrl_d = raise_flag(srst_q, ctrl_q, code_d);
                    end else begin
                        code_d = ST_AW_NACK;
                    end
                end
                PW_SEND: begin
                    if (back_i) begin
                        code_d = ST_TX_ACK;
                        ctrl_d = raise_flag(srst_q, ctrl_q, code_d);
                    end else begin
                        code_d  = ST_TX_NACK;
                        issue_o = 1'b1;
                        iop_o   = BOP_STOP;
                        pend_d  = PW_STOP;
                    end
                end
                PW_RECV: begin
                    data_d  = brdata_i;
                    code_d  = rx_code(ctrl_q[CB_AAK]);
                    ctrl_d  = raise_flag(srst_q, ctrl_q, code_d);
                    rsp_v_d = 1'b1;
                    rsp_b_d = brdata_i;
                end
                default: ;
            endcase
        end else if (acc_i && acc_wr_i) begin
            case (off8)
                OFF_SADDR: saddr_d = acc_wbyte_i;
                OFF_XADDR: xaddr_d = acc_wbyte_i;
                OFF_CLK:   clk_d   = acc_wbyte_i & MSK_CLK;
                OFF_FEAT:  feat_d  = acc_wbyte_i & MSK_FEAT;
                OFF_LINE:  line_d  = acc_wbyte_i & MSK_LINE;
                OFF_DATA: begin
                    if (!srst_q && ctrl_q[CB_EN]) begin
                        data_d = acc_wbyte_i;
                        if ((code_q == ST_START) || (code_q == ST_RSTART)) begin
                            issue_o = 1'b1;
                            iop_o   = BOP_START;
                            pend_d  = PW_ADDR;
                        end else if ((code_q == ST_AW_ACK) || (code_q == ST_TX_ACK)) begin
                            issue_o = 1'b1;
                            iop_o   = BOP_SEND;
                            pend_d  = PW_SEND;
                        end
                    end
                end
                OFF_CTRL: begin
                    if (!srst_q) begin
                        c_v = acc_wbyte_i & MSK_CTRL;
                        if (CLR_ON_ONE)
                            c_v[CB_FLG] = acc_wbyte_i[CB_FLG] ? 1'b0 : ctrl_q[CB_FLG];
                        else
                            c_v[CB_FLG] = acc_wbyte_i[CB_FLG] ? ctrl_q[CB_FLG] : 1'b0;
                        if (c_v[CB_STA]) begin
                            k_v         = (code_q == ST_IDLE) ? ST_START : ST_RSTART;
                            c_v[CB_STA] = 1'b0;
                            rs_v        = 1'b1;
                        end
                        if (c_v[CB_STP]) begin
                            k_v         = ST_IDLE;
                            c_v[CB_STP] = 1'b0;
                            issue_o     = 1'b1;
                            iop_o       = BOP_STOP;
                            pend_d      = PW_STOP;
                        end
                        if (!c_v[CB_AAK] && (k_v == ST_RX_ACK))
                            k_v = ST_RX_NACK;
                        else if (c_v[CB_AAK] && (k_v == ST_RX_NACK))
                            k_v = ST_RX_ACK;
                        if (rs_v)
                            c_v = raise_flag(srst_q, c_v, k_v);
                        ctrl_d = c_v;
                        code_d = k_v;
                    end
                end
                OFF_SRST: begin
                    if (srst_q && !acc_wbyte_i[0]) begin
                        saddr_d = '0;
                        xaddr_d = '0;
                        data_d  = '0;
                        ctrl_d  = '0;
                        code_d  = ST_IDLE;
                        clk_d   = '0;
                        feat_d  = '0;
                        line_d  = RST_LINE;
                        if (code_q != ST_IDLE) begin
                            issue_o = 1'b1;
                            iop_o   = BOP_STOP;
                            pend_d  = PW_STOP;
                        end
                    end
                    srst_d = acc_wbyte_i[0];
                end
                default: ;
            endcase
        end else if (acc_i) begin
            if ((off8 == OFF_DATA) &&
                ((code_q == ST_AR_ACK) || (code_q == ST_RX_ACK) || (code_q == ST_RX_NACK))) begin
                issue_o = 1'b1;
                iop_o   = BOP_RECV;
                pend_d  = PW_RECV;
            end else begin
                rsp_v_d = 1'b1;
                rsp_b_d = rd_value_i;
                if ((off8 == OFF_STAT) && (code_q == ST_AR_ACK)) begin
                    code_d = rx_code(ctrl_q[CB_AAK]);
                    ctrl_d = raise_flag(srst_q, ctrl_q, code_d);
                end
            end
        end
    end

    // State registers with their reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saddr_q     <= '0;
            xaddr_q     <= '0;
            data_q      <= '0;
            ctrl_q      <= '0;
            code_q      <= ST_IDLE;
            clk_q       <= '0;
            srst_q      <= 1'b0;
            feat_q      <= '0;
            line_q      <= RST_LINE;
            pend_q      <= PW_NONE;
            rsp_valid_o <= 1'b0;
            rsp_data_o  <= '0;
        end else begin
            saddr_q     <= saddr_d;
            xaddr_q     <= xaddr_d;
            data_q      <= data_d;
            ctrl_q      <= ctrl_d;
            code_q      <= code_d;
            clk_q       <= clk_d;
            srst_q      <= srst_d;
            feat_q      <= feat_d;
            line_q      <= line_d;
            pend_q      <= pend_d;
            rsp_valid_o <= rsp_v_d;
            rsp_data_o  <= rsp_b_d;
        end
    end

    assign saddr_o = saddr_q;
    assign xaddr_o = xaddr_q;
    assign data_o  = data_q;
    assign ctrl_o  = ctrl_q;
    assign code_o  = code_q;
    assign clk_o   = clk_q;
    assign srst_o  = srst_q;
    assign feat_o  = feat_q;
    assign line_o  = line_q;
    assign irq_o   = ctrl_q[CB_IE] & ctrl_q[CB_FLG] & ~srst_q;

endmodule

// File: rtl/i2cm_regfront.sv
// Module: top of the register-mapped I2C master sequencer.
// Assumes a host that raises host_req_i for one cycle while host_ready_o is
// high, and a bus side that completes each request with one done pulse.
module i2cm_regfront #(
    parameter int ADDR_W     = 6,
    parameter bit CLR_ON_ONE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req_i,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_off_i,
    input  logic [7:0]        host_wdata_i,
    output logic              host_ready_o,
    output logic              rsp_valid_o,
    output logic [7:0]        rsp_data_o,
    output logic              irq_o,
    output logic              bus_req_o,
    output logic [1:0]        bus_op_o,
    output logic [6:0]        bus_addr_o,
    output logic              bus_rnw_o,
    output logic [7:0]        bus_wdata_o,
    input  logic              bus_done_i,
    input  logic              bus_ack_i,
    input  logic [7:0]        bus_rdata_i
);
    import i2cm_pkg::*;

    logic       busy_w, done_w, acc_w, issue_w, irnw_w, srst_w;
    bus_op_e    iop_w, bop_w;
    logic [6:0] iaddr_w;
    logic [7:0] iwbyte_w, rdval_w;
    logic [7:0] saddr_w, xaddr_w, data_w, cntr_w, clk_w, feat_w, line_w;
    logic [4:0] stat_code;

    assign host_ready_o = ~busy_w;
    assign acc_w        = host_req_i & ~busy_w;
    assign bus_op_o     = bop_w;

    i2cm_ctrl #(
        .ADDR_W     (ADDR_W),
        .CLR_ON_ONE (CLR_ON_ONE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_i       (acc_w),
        .acc_wr_i    (host_wr_i),
        .acc_off_i   (host_off_i),
        .acc_wbyte_i (host_wdata_i),
        .rd_value_i  (rdval_w),
        .bdone_i     (done_w),
        .back_i      (bus_ack_i),
        .brdata_i    (bus_rdata_i),
        .issue_o     (issue_w),
        .iop_o       (iop_w),
        .iaddr_o     (iaddr_w),
        .irnw_o      (irnw_w),
        .iwbyte_o    (iwbyte_w),
        .saddr_o     (saddr_w),
        .xaddr_o     (xaddr_w),
        .data_o      (data_w),
        .ctrl_o      (cntr_w),
        .code_o      (stat_code),
        .clk_o       (clk_w),
        .srst_o      (srst_w),
        .feat_o      (feat_w),
        .line_o      (line_w),
        .irq_o       (irq_o),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o)
    );

    i2cm_rdmux #(
        .ADDR_W (ADDR_W)
    ) u_rdmux (
        .off_i   (host_off_i),
        .saddr_i (saddr_w),
        .xaddr_i (xaddr_w),
        .data_i  (data_w),
        .ctrl_i  (cntr_w),
        .code_i  (stat_code),
        .clk_i   (clk_w),
        .srst_i  (srst_w),
        .feat_i  (feat_w),
        .line_i  (line_w),
        .value_o (rdval_w)
    );

    i2cm_bus_if u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (issue_w),
        .op_i        (iop_w),
        .addr_i      (iaddr_w),
        .rnw_i       (irnw_w),
        .wbyte_i     (iwbyte_w),
        .bus_done_i  (bus_done_i),
        .bus_req_o   (bus_req_o),
        .bus_op_o    (bop_w),
        .bus_addr_o  (bus_addr_o),
        .bus_rnw_o   (bus_rnw_o),
        .bus_wdata_o (bus_wdata_o),
        .busy_o      (busy_w),
        .done_o      (done_w)
    );

endmodule

// File: rtl/i2cm_regfront_chk.sv
// Module: property checker for i2cm_regfront, attached with bind below.
// Assumes it sees the top's ports plus the status code, control image and
// soft-reset state as driven by the sequencer.
module i2cm_regfront_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req_i,
    input logic              host_wr_i,
    input logic [ADDR_W-1:0] host_off_i,
    input logic [7:0]        host_wdata_i,
    input logic              host_ready_o,
    input logic              rsp_valid_o,
    input logic              irq_o,
    input logic              bus_req_o,
    input logic              bus_done_i,
    input logic [4:0]        stat_code,
    input logic [7:0]        cntr_w,
    input logic              srst_w
);

    logic acc;
    assign acc = host_req_i & host_ready_o;

    // R12
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |=> !bus_req_o);

    // R12
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> !host_ready_o);

    // R12
    rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> ($past(acc && !host_wr_i) || $past(bus_done_i)));

    // R10
    dis_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && host_wr_i && (8'(host_off_i) == 8'h08) && !cntr_w[6]) |=> !bus_req_o);

    // R3
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && host_wr_i && (8'(host_off_i) == 8'h0C) && host_wdata_i[4] && !srst_w)
        |=> (stat_code == 5'd31));

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(acc) || $past(bus_done_i)));

endmodule

bind i2cm_regfront i2cm_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req_i   (host_req_i),
    .host_wr_i    (host_wr_i),
    .host_off_i   (host_off_i),
    .host_wdata_i (host_wdata_i),
    .host_ready_o (host_ready_o),
    .rsp_valid_o  (rsp_valid_o),
    .irq_o        (irq_o),
    .bus_req_o    (bus_req_o),
    .bus_done_i   (bus_done_i),
    .stat_code    (stat_code),
    .cntr_w       (cntr_w),
    .srst_w       (srst_w)
);

// File: tb/sim_i2cm_regfront.sv
// Bench: directed scenarios for the I2C master register front end.
module sim_i2cm_regfront;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_req_i = 1'b0;
    logic       host_wr_i = 1'b0;
    logic [5:0] host_off_i = '0;
    logic [7:0] host_wdata_i = '0;
    logic       host_ready_o, rsp_valid_o, irq_o;
    logic [7:0] rsp_data_o;
    logic       bus_req_o, bus_rnw_o;
    logic [1:0] bus_op_o;
    logic [6:0] bus_addr_o;
    logic [7:0] bus_wdata_o;
    logic       bus_done_i = 1'b0;
    logic       bus_ack_i = 1'b0;
    logic [7:0] bus_rdata_i = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bus model state
    bit         addr_ack = 1'b1;
    bit         send_ack = 1'b1;
    int         req_cnt = 0;
    int         stop_cnt = 0;
    logic [1:0] last_op;
    logic [6:0] last_addr;
    logic       last_rnw;
    logic [7:0] last_wdata;
    logic [7:0] rx_next = 8'h3C;
    logic       rdy_after;

    always #10 clk = ~clk;

    i2cm_regfront u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req_i   (host_req_i),
        .host_wr_i    (host_wr_i),
        .host_off_i   (host_off_i),
        .host_wdata_i (host_wdata_i),
        .host_ready_o (host_ready_o),
        .rsp_valid_o  (rsp_valid_o),
        .rsp_data_o   (rsp_data_o),
        .irq_o        (irq_o),
        .bus_req_o    (bus_req_o),
        .bus_op_o     (bus_op_o),
        .bus_addr_o   (bus_addr_o),
        .bus_rnw_o    (bus_rnw_o),
        .bus_wdata_o  (bus_wdata_o),
        .bus_done_i   (bus_done_i),
        .bus_ack_i    (bus_ack_i),
        .bus_rdata_i  (bus_rdata_i)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Bus responder: two cycles of latency per request
    initial begin
        forever begin
            @(negedge clk);
            while (bus_req_o) begin
                req_cnt++;
                last_op    = bus_op_o;
                last_addr  = bus_addr_o;
                last_rnw   = bus_rnw_o;
                last_wdata = bus_wdata_o;
                if (bus_op_o == 2'd3) stop_cnt++;
                repeat (2) @(negedge clk);
                bus_done_i  = 1'b1;
                bus_ack_i   = (bus_op_o == 2'd0) ? addr_ack :
                              (bus_op_o == 2'd1) ? send_ack : 1'b1;
                bus_rdata_i = rx_next;
                if (bus_op_o == 2'd2) rx_next = rx_next + 8'd1;
                @(negedge clk);
                bus_done_i = 1'b0;
                bus_ack_i  = 1'b0;
            end
        end
    end

    task automatic wait_ready();
        while (!host_ready_o) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] off, input logic [7:0] val);
        @(negedge clk);
        wait_ready();
        host_req_i   = 1'b1;
        host_wr_i    = 1'b1;
        host_off_i   = off;
        host_wdata_i = val;
        @(negedge clk);
        host_req_i = 1'b0;
        rdy_after  = host_ready_o;
        wait_ready();
    endtask

    task automatic rd(input logic [5:0] off, output logic [7:0] val);
        @(negedge clk);
        wait_ready();
        host_req_i = 1'b1;
        host_wr_i  = 1'b0;
        host_off_i = off;
        @(negedge clk);
        host_req_i = 1'b0;
        for (int i = 0; i < 50 && !rsp_valid_o; i++) @(negedge clk);
        val = rsp_valid_o ? rsp_data_o : 8'hXX;
        wait_ready();
    endtask

    task automatic rd_chk(input string req, input logic [5:0] off, input logic [7:0] exp);
        logic [7:0] v;
        rd(off, v);
        check(req, v, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 status", 6'h10, 8'hF8);
        rd_chk("R1 line", 6'h20, 8'h3A);
        rd_chk("R1 ctrl", 6'h0C, 8'h00);
        rd_chk("R1 clk", 6'h14, 8'h00);
        check("R1 irq", {7'd0, irq_o}, 8'h00);
        check("R1 ready", {7'd0, host_ready_o}, 8'h01);
    endtask

    task automatic t_masks();
        wr(6'h14, 8'hFF);  rd_chk("R2 clk mask", 6'h14, 8'h7F);
        wr(6'h1C, 8'hFF);  rd_chk("R2 feat mask", 6'h1C, 8'h03);
        wr(6'h20, 8'hFF);  rd_chk("R2 line mask", 6'h20, 8'h3F);
        wr(6'h00, 8'hA7);  rd_chk("R2 saddr", 6'h00, 8'hA7);
        wr(6'h04, 8'h11);  rd_chk("R2 xaddr", 6'h04, 8'h11);
        wr(6'h24, 8'h55);  rd_chk("R2 unknown", 6'h24, 8'h00);
    endtask

    task automatic t_start_clear();
        wr(6'h0C, 8'hE4);
        rd_chk("R3 start code", 6'h10, 8'h08);
        rd_chk("R7 start raise", 6'h0C, 8'hCC);
        check("R7 irq on", {7'd0, irq_o}, 8'h01);
        wr(6'h0C, 8'hC4);
        rd_chk("R8 clear by 0", 6'h0C, 8'hC4);
        check("R8 irq off", {7'd0, irq_o}, 8'h00);
        wr(6'h0C, 8'hCC);
        rd_chk("R8 write 1 keeps", 6'h0C, 8'hC4);
    endtask

    task automatic t_addr_send();
        int r0;
        r0 = req_cnt;
        wr(6'h08, 8'hA4);
        check("R12 ready low", {7'd0, rdy_after}, 8'h00);
        check("R12 one request", 8'(req_cnt - r0), 8'h01);
        check("R4 op", {6'd0, last_op}, 8'h00);
        check("R4 addr", {1'b0, last_addr}, 8'h52);
        check("R4 dir", {7'd0, last_rnw}, 8'h00);
        rd_chk("R4 code 3", 6'h10, 8'h18);
        rd_chk("R4 raise", 6'h0C, 8'hCC);
        wr(6'h0C, 8'hC4);
        wr(6'h08, 8'h5A);
        check("R5 send byte", last_wdata, 8'h5A);
        rd_chk("R5 code 5", 6'h10, 8'h28);
        rd_chk("R5 raise", 6'h0C, 8'hCC);
        wr(6'h0C, 8'hC4);
        send_ack = 1'b0;
        r0 = stop_cnt;
        wr(6'h08, 8'h99);
        rd_chk("R5 code 6", 6'h10, 8'h30);
        check("R5 chained stop", 8'(stop_cnt - r0), 8'h01);
        rd_chk("R5 no raise", 6'h0C, 8'hC4);
        send_ack = 1'b1;
    endtask

    task automatic t_read_path();
        wr(6'h0C, 8'hE4);
        rd_chk("R3 restart code", 6'h10, 8'h10);
        wr(6'h08, 8'hA5);
        check("R4 read dir", {7'd0, last_rnw}, 8'h01);
        rd_chk("R6 code 8", 6'h10, 8'h40);
        rd_chk("R6 advance", 6'h10, 8'h50);
        rd_chk("R6 byte", 6'h08, 8'h3C);
        rd_chk("R6 after byte", 6'h10, 8'h50);
        wr(6'h0C, 8'hC0);
        rd_chk("R9 to nack", 6'h10, 8'h58);
        rd_chk("R6 byte 2", 6'h08, 8'h3D);
        rd_chk("R6 nack code", 6'h10, 8'h58);
        wr(6'h0C, 8'hC4);
        rd_chk("R9 to ack", 6'h10, 8'h50);
    endtask

    task automatic t_stop_gate();
        int s0;
        s0 = stop_cnt;
        wr(6'h0C, 8'hD4);
        rd_chk("R3 stop idle", 6'h10, 8'hF8);
        rd_chk("R3 stop clears", 6'h0C, 8'hC4);
        check("R3 stop issued", 8'(stop_cnt - s0), 8'h01);
        wr(6'h0C, 8'h64);
        rd_chk("R7 flag no ie", 6'h0C, 8'h4C);
        check("R7 irq gated", {7'd0, irq_o}, 8'h00);
        wr(6'h0C, 8'hCC);
        check("R7 irq enabled", {7'd0, irq_o}, 8'h01);
        wr(6'h0C, 8'h54);
    endtask

    task automatic t_addr_nack();
        wr(6'h0C, 8'h64);
        wr(6'h0C, 8'h44);
        addr_ack = 1'b0;
        wr(6'h08, 8'h20);
        rd_chk("R4 nack code", 6'h10, 8'h20);
        rd_chk("R4 nack no raise", 6'h0C, 8'h44);
        addr_ack = 1'b1;
        wr(6'h0C, 8'h54);
    endtask

    task automatic t_ignore_srst();
        int r0, s0;
        wr(6'h0C, 8'h04);
        r0 = req_cnt;
        wr(6'h08, 8'h77);
        rd_chk("R10 data kept", 6'h08, 8'h20);
        check("R10 no request", 8'(req_cnt - r0), 8'h00);
        wr(6'h18, 8'h01);
        wr(6'h0C, 8'h44);
        rd_chk("R10 ctrl ignored", 6'h0C, 8'h04);
        wr(6'h14, 8'h05);
        rd_chk("R11 clk in srst", 6'h14, 8'h05);
        s0 = stop_cnt;
        wr(6'h18, 8'h00);
        rd_chk("R11 clk reset", 6'h14, 8'h00);
        rd_chk("R11 line reset", 6'h20, 8'h3A);
        rd_chk("R11 saddr reset", 6'h00, 8'h00);
        rd_chk("R11 srst reads 0", 6'h18, 8'h00);
        check("R11 idle no stop", 8'(stop_cnt - s0), 8'h00);
        wr(6'h0C, 8'h64);
        wr(6'h18, 8'h01);
        s0 = stop_cnt;
        wr(6'h18, 8'h00);
        check("R11 stop on release", 8'(stop_cnt - s0), 8'h01);
        rd_chk("R11 status idle", 6'h10, 8'hF8);
        rd_chk("R11 ctrl reset", 6'h0C, 8'h00);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Scenario sequence
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_start_clear();
        t_addr_send();
        t_read_path();
        t_stop_gate();
        t_addr_nack();
        t_ignore_srst();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule